// File: doc/BRIEF.md
# Star Cluster Region Grower

This block searches a small image stripe, held in an on-chip pixel memory, for star clusters. A raster scan looks for seed pixels that are brighter than a seed threshold. Around each seed it grows a cluster: it visits 8-connected neighbours whose value is above a lower growing threshold, and it keeps the growth inside a square window centred on the seed. An explicit coordinate stack replaces recursion. A one-bit-per-pixel examined map makes sure no pixel is looked at twice. When a cluster is complete, the block reports its bounding box and its seed.

Stripes overlap vertically. A seed whose window would run past the bottom row of the current stripe is therefore not grown. It is pushed onto a second stack, and those seeds are reported one by one after the scan so that the next stripe can handle them. Software can rewrite both thresholds at any time through a simple write strobe. The pixel memory is loaded through a plain write port while the block is idle.

A scan is started by pulsing `start`. `busy` stays high for the whole scan, and `done` pulses once after the last deferred seed has been reported.

Top module: `sc_cluster_finder`

## Requirements
- R1: A pixel becomes a seed only when its value is strictly greater than the seed threshold. A pixel equal to the threshold starts no cluster.
- R2: A neighbour joins a cluster when it is 8-adjacent to a pixel already in the cluster, its value is strictly greater than the growing threshold, and it lies within ROI_HALF (default 2) rows and columns of the seed. The bounding box therefore never spans more than 2*ROI_HALF+1 rows or columns.
- R3: The four corner cells of the window (row and column offset from the seed both equal to ROI_HALF) never join a cluster, even when they are bright and adjacent to it.
- R4: Each pixel is examined at most once per scan. A bright pixel that has already joined a cluster does not start a new one, so two adjacent seeds give one cluster, reported with the first seed in raster order.
- R5: For each finished cluster, `clu_valid` pulses for one cycle. With it come the minimum and maximum row and column of the member pixels and the seed coordinate, and the seed lies inside the box.
- R6: A seed whose row is greater than ROWS-1-ROI_HALF is not grown. It is held on the deferred stack. After the scan, each deferred seed is reported on `defer_valid`, one per cycle, last deferred first.
- R7: If a push onto the growth stack would exceed MAIN_DEPTH, `err_overflow` pulses, the cluster is dropped with no `clu_valid`, and the scan continues. The same pulse marks a seed lost to a full deferred stack.
- R8: `thr_we` with `thr_sel`=0 writes the seed threshold and with `thr_sel`=1 writes the growing threshold. A new growing threshold changes which neighbours join on the next scan.
- R9: After reset, `busy`, `done`, `clu_valid`, `defer_valid` and `err_overflow` are low. The thresholds take their reset parameter values.
- R10: `done` pulses for exactly one cycle at the end of a scan, with `busy` low in that cycle.
- R11: Near the image edges the window is clipped. Growth never reads outside the stripe, and a seed in row 0, column 0 gives a box that starts at row 0 and column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 1 | 0 selects the seed threshold, 1 selects the growing threshold |
| thr_wdata | input | PIX_W | New threshold value |
| pix_we | input | 1 | Pixel memory write strobe, accepted only while idle |
| pix_waddr | input | RW+CW | Pixel address {row, column} |
| pix_wdata | input | PIX_W | Pixel value |
| start | input | 1 | Starts a scan when idle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| clu_valid | output | 1 | One-cycle cluster report |
| clu_row_min | output | RW | Top row of the cluster |
| clu_row_max | output | RW | Bottom row of the cluster |
| clu_col_min | output | CW | Left column of the cluster |
| clu_col_max | output | CW | Right column of the cluster |
| clu_seed_row | output | RW | Seed row |
| clu_seed_col | output | CW | Seed column |
| defer_valid | output | 1 | One-cycle deferred-seed report |
| defer_row | output | RW | Deferred seed row |
| defer_col | output | CW | Deferred seed column |
| err_overflow | output | 1 | One-cycle stack overflow pulse |

## Verification
Suppose the examined map is cleared late or indexed wrongly. Then, within the same scan, an adjacent second seed gives an extra `clu_valid`, or a pixel is absorbed twice. Suppose instead the growth stack's top entry keeps a stale neighbour position. Then growth either loops until the watchdog fires or stops early, and the reported box is too small as soon as `clu_valid` appears. Window and corner faults show up directly in the box edges. Faults in the deferral path show up as an early `clu_valid` for a low seed, or as deferred seeds reported in the wrong order before `done`.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN_RD,
      ST_SCAN_CHK,
      ST_GROW_STEP,
      ST_GROW_CHK,
      ST_DRAIN
   } sc_state_e;

   localparam logic THR_SEL_SEED = 1'b0;
   localparam logic THR_SEL_GROW = 1'b1;

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

endpackage

// File: rtl/sc_stripe_ram.sv
module sc_stripe_ram #(
   parameter int DEPTH = 128,
   parameter int AW    = 7,
   parameter int DW    = 12
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   generate
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("sc_stripe_ram: address too narrow for depth");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/sc_lifo.sv
module sc_lifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic         pop,
   input  logic         top_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] top_wdata,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full
);

   localparam int CNTW = $clog2(DEPTH + 1);

   logic [W-1:0]    mem [DEPTH];
   logic [CNTW-1:0] cnt;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sc_lifo: DEPTH must be at least 1");
      end
   endgenerate

   assign empty = (cnt == '0);
   assign full  = (cnt == CNTW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (push && !full)    cnt <= cnt + 1'b1;
      else if (pop && !empty)    cnt <= cnt - 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && !full && cnt == CNTW'(i))
            mem[i] <= wdata;
         else if (top_we && !empty && cnt == CNTW'(i + 1))
            mem[i] <= top_wdata;
      end
   end

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++)
         if (cnt == CNTW'(i + 1)) top = mem[i];
   end

endmodule

// File: rtl/sc_visit_map.sv
module sc_visit_map #(
   parameter int N  = 128,
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set,
   input  logic [AW-1:0] set_addr,
   input  logic [AW-1:0] q_addr,
   output logic          q_hit
);

   logic [N-1:0] bits;

   generate
      if ((1 << AW) != N) begin : g_bad_n
         $error("sc_visit_map: N must equal 2**AW");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bits <= '0;
      else if (clr)  bits <= '0;
      else if (set)  bits[set_addr] <= 1'b1;
   end

   assign q_hit = bits[q_addr];

endmodule

// File: rtl/sc_cluster_finder.sv
module sc_cluster_finder
   import sc_pkg::*;
#(
   parameter int ROWS         = 8,
   parameter int COLS         = 16,
   parameter int PIX_W        = 12,
   parameter int ROI_HALF     = 2,
   parameter int MAIN_DEPTH   = 24,
   parameter int DEFER_DEPTH  = 4,
   parameter bit SKIP_CORNERS = 1'b1,
   parameter int SEED_THR_RST = 2000,
   parameter int GROW_THR_RST = 1000,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_we,
   input  logic             thr_sel,
   input  logic [PIX_W-1:0] thr_wdata,
   input  logic             pix_we,
   input  logic [RW+CW-1:0] pix_waddr,
   input  logic [PIX_W-1:0] pix_wdata,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             clu_valid,
   output logic [RW-1:0]    clu_row_min,
   output logic [RW-1:0]    clu_row_max,
   output logic [CW-1:0]    clu_col_min,
   output logic [CW-1:0]    clu_col_max,
   output logic [RW-1:0]    clu_seed_row,
   output logic [CW-1:0]    clu_seed_col,
   output logic             defer_valid,
   output logic [RW-1:0]    defer_row,
   output logic [CW-1:0]    defer_col,
   output logic             err_overflow
);

   localparam int AW            = RW + CW;
   localparam int NPIX          = ROWS * COLS;
   localparam int PW            = 4;
   localparam int EW            = RW + CW + PW;
   localparam int LAST_GROW_ROW = ROWS - 1 - ROI_HALF;
   localparam logic [PW-1:0] POS_CENTRE = PW'(4);
   localparam logic [PW-1:0] POS_END    = PW'(9);

   // elaboration checks
   generate
      if ((1 << RW) != ROWS) begin : g_bad_rows
         $error("sc_cluster_finder: ROWS must be a power of two");
      end
      if ((1 << CW) != COLS) begin : g_bad_cols
         $error("sc_cluster_finder: COLS must be a power of two");
      end
      if (ROI_HALF < 1 || 2 * ROI_HALF + 1 > ROWS || 2 * ROI_HALF + 1 > COLS) begin : g_bad_roi
         $error("sc_cluster_finder: window does not fit the stripe");
      end
      if (MAIN_DEPTH < 2 || DEFER_DEPTH < 1) begin : g_bad_stacks
         $error("sc_cluster_finder: stack depths too small");
      end
      if (GROW_THR_RST >= SEED_THR_RST || SEED_THR_RST >= (1 << PIX_W)) begin : g_bad_thr
         $error("sc_cluster_finder: reset thresholds out of order or range");
      end
   endgenerate

   // state
   sc_state_e        st, st_nx;
   logic [PIX_W-1:0] seed_thr, grow_thr;
   logic [RW-1:0]    sc_r, seed_r, n_r, bb_rmin, bb_rmax;
   logic [CW-1:0]    sc_c, seed_c, n_c, bb_cmin, bb_cmax;
   logic             scan_last, drop;

   // submodule wiring
   logic [AW-1:0]    rd_addr, vis_addr, vq_addr;
   logic [PIX_W-1:0] rd_data;
   logic             vis_clr, vis_set, vq_hit;
   logic             m_push, m_pop, m_clr, m_top_we, m_empty, m_full;
   logic [EW-1:0]    m_wdata, m_top_wdata, m_top;
   logic             d_push, d_pop, d_empty, d_full;
   logic [AW-1:0]    d_top;

   // events
   logic ev_begin, ev_adv, ev_seed, ev_cand, ev_join, ev_drop;
   logic ev_clu, ev_err, ev_defer, ev_done;

   sc_stripe_ram #(.DEPTH(NPIX), .AW(AW), .DW(PIX_W)) u_ram (
      .clk   (clk),
      .we    (pix_we && st == ST_IDLE),
      .waddr (pix_waddr),
      .wdata (pix_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   sc_visit_map #(.N(NPIX), .AW(AW)) u_seen (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (vis_clr),
      .set      (vis_set),
      .set_addr (vis_addr),
      .q_addr   (vq_addr),
      .q_hit    (vq_hit)
   );

   sc_lifo #(.W(EW), .DEPTH(MAIN_DEPTH)) u_grow_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (m_clr),
      .push      (m_push),
      .pop       (m_pop),
      .top_we    (m_top_we),
      .wdata     (m_wdata),
      .top_wdata (m_top_wdata),
      .top       (m_top),
      .empty     (m_empty),
      .full      (m_full)
   );

   sc_lifo #(.W(AW), .DEPTH(DEFER_DEPTH)) u_defer_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (1'b0),
      .push      (d_push),
      .pop       (d_pop),
      .top_we    (1'b0),
      .wdata     ({sc_r, sc_c}),
      .top_wdata ('0),
      .top       (d_top),
      .empty     (d_empty),
      .full      (d_full)
   );

   // neighbour candidate from the growth stack top
   logic [RW-1:0] t_r, nb_r;
   logic [CW-1:0] t_c, nb_c;
   logic [PW-1:0] t_pos;
   logic          nb_inside, nb_in_roi, nb_corner, corner_block, nb_cand;

   assign t_pos = m_top[PW-1:0];
   assign t_c   = m_top[PW+CW-1:PW];
   assign t_r   = m_top[EW-1:PW+CW];

   always_comb begin
      int dr, dc, nr, nc, odr, odc;
      dr  = int'(t_pos) / 3 - 1;
      dc  = int'(t_pos) % 3 - 1;
      nr  = int'(t_r) + dr;
      nc  = int'(t_c) + dc;
      odr = iabs(nr - int'(seed_r));
      odc = iabs(nc - int'(seed_c));
      nb_inside = (nr >= 0) && (nr < ROWS) && (nc >= 0) && (nc < COLS);
      nb_in_roi = (odr <= ROI_HALF) && (odc <= ROI_HALF);
      nb_corner = (odr == ROI_HALF) && (odc == ROI_HALF);
      nb_r      = RW'(nr);
      nb_c      = CW'(nc);
   end

   generate
      if (SKIP_CORNERS) begin : g_corner_skip
         assign corner_block = nb_corner;
      end else begin : g_corner_keep
         assign corner_block = 1'b0;
      end
   endgenerate

   assign nb_cand = (t_pos != POS_CENTRE) && (t_pos < POS_END) &&
                    nb_inside && nb_in_roi && !corner_block;

   // control
   logic scan_at_end, seed_hit;
   assign scan_at_end = (sc_r == RW'(ROWS - 1)) && (sc_c == CW'(COLS - 1));
   assign seed_hit    = (rd_data > seed_thr) && !vq_hit;

   always_comb begin
      st_nx       = st;
      rd_addr     = {sc_r, sc_c};
      vis_clr     = 1'b0;
      vis_set     = 1'b0;
      vis_addr    = {sc_r, sc_c};
      vq_addr     = {sc_r, sc_c};
      m_push      = 1'b0;
      m_pop       = 1'b0;
      m_clr       = 1'b0;
      m_top_we    = 1'b0;
      m_wdata     = {sc_r, sc_c, PW'(0)};
      m_top_wdata = {t_r, t_c, t_pos + 1'b1};
      d_push      = 1'b0;
      d_pop       = 1'b0;
      ev_begin    = 1'b0;
      ev_adv      = 1'b0;
      ev_seed     = 1'b0;
      ev_cand     = 1'b0;
      ev_join     = 1'b0;
      ev_drop     = 1'b0;
      ev_clu      = 1'b0;
      ev_err      = 1'b0;
      ev_defer    = 1'b0;
      ev_done     = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               vis_clr  = 1'b1;
               ev_begin = 1'b1;
               st_nx    = ST_SCAN_RD;
            end
         end
         ST_SCAN_RD: st_nx = ST_SCAN_CHK;
         ST_SCAN_CHK: begin
            ev_adv = 1'b1;
            st_nx  = scan_at_end ? ST_DRAIN : ST_SCAN_RD;
            if (seed_hit) begin
               if (int'(sc_r) > LAST_GROW_ROW) begin
                  if (d_full) ev_err = 1'b1;
                  else        d_push = 1'b1;
               end else begin
                  vis_set = 1'b1;
                  m_push  = 1'b1;
                  ev_seed = 1'b1;
                  st_nx   = ST_GROW_STEP;
               end
            end
         end
         ST_GROW_STEP: begin
            vq_addr = {nb_r, nb_c};
            if (m_empty) begin
               ev_clu = !drop;
               st_nx  = scan_last ? ST_DRAIN : ST_SCAN_RD;
            end else if (t_pos >= POS_END) begin
               m_pop = 1'b1;
            end else begin
               m_top_we = 1'b1;
               if (nb_cand && !vq_hit) begin
                  rd_addr = {nb_r, nb_c};
                  ev_cand = 1'b1;
                  st_nx   = ST_GROW_CHK;
               end
            end
         end
         ST_GROW_CHK: begin
            vis_set  = 1'b1;
            vis_addr = {n_r, n_c};
            st_nx    = ST_GROW_STEP;
            if (rd_data > grow_thr) begin
               if (m_full) begin
                  ev_err  = 1'b1;
                  ev_drop = 1'b1;
                  m_clr   = 1'b1;
               end else begin
                  m_push  = 1'b1;
                  m_wdata = {n_r, n_c, PW'(0)};
                  ev_join = 1'b1;
               end
            end
         end
         ST_DRAIN: begin
            if (d_empty) begin
               ev_done = 1'b1;
               st_nx   = ST_IDLE;
            end else begin
               d_pop    = 1'b1;
               ev_defer = 1'b1;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         seed_thr     <= PIX_W'(SEED_THR_RST);
         grow_thr     <= PIX_W'(GROW_THR_RST);
         sc_r         <= '0;
         sc_c         <= '0;
         scan_last    <= 1'b0;
         seed_r       <= '0;
         seed_c       <= '0;
         n_r          <= '0;
         n_c          <= '0;
         bb_rmin      <= '0;
         bb_rmax      <= '0;
         bb_cmin      <= '0;
         bb_cmax      <= '0;
         drop         <= 1'b0;
         done         <= 1'b0;
         clu_valid    <= 1'b0;
         clu_row_min  <= '0;
         clu_row_max  <= '0;
         clu_col_min  <= '0;
         clu_col_max  <= '0;
         clu_seed_row <= '0;
         clu_seed_col <= '0;
         defer_valid  <= 1'b0;
         defer_row    <= '0;
         defer_col    <= '0;
         err_overflow <= 1'b0;
      end else begin
         st           <= st_nx;
         done         <= ev_done;
         clu_valid    <= ev_clu;
         defer_valid  <= ev_defer;
         err_overflow <= ev_err;
         if (thr_we) begin
            if (thr_sel == THR_SEL_SEED) seed_thr <= thr_wdata;
            else                         grow_thr <= thr_wdata;
         end
         if (ev_begin) begin
            sc_r      <= '0;
            sc_c      <= '0;
            scan_last <= 1'b0;
         end
         if (ev_adv) begin
            scan_last <= scan_at_end;
            if (sc_c == CW'(COLS - 1)) begin
               sc_c <= '0;
               sc_r <= sc_r + 1'b1;
            end else begin
               sc_c <= sc_c + 1'b1;
            end
         end
         if (ev_seed) begin
            seed_r  <= sc_r;
            seed_c  <= sc_c;
            bb_rmin <= sc_r;
            bb_rmax <= sc_r;
            bb_cmin <= sc_c;
            bb_cmax <= sc_c;
            drop    <= 1'b0;
         end
         if (ev_cand) begin
            n_r <= nb_r;
            n_c <= nb_c;
         end
         if (ev_join) begin
            if (n_r < bb_rmin) bb_rmin <= n_r;
            if (n_r > bb_rmax) bb_rmax <= n_r;
            if (n_c < bb_cmin) bb_cmin <= n_c;
            if (n_c > bb_cmax) bb_cmax <= n_c;
         end
         if (ev_drop) drop <= 1'b1;
         if (ev_clu) begin
            clu_row_min  <= bb_rmin;
            clu_row_max  <= bb_rmax;
            clu_col_min  <= bb_cmin;
            clu_col_max  <= bb_cmax;
            clu_seed_row <= seed_r;
            clu_seed_col <= seed_c;
         end
         if (ev_defer) begin
            defer_row <= d_top[AW-1:CW];
            defer_col <= d_top[CW-1:0];
         end
      end
   end

endmodule

// File: rtl/sc_cluster_finder_chk.sv
module sc_cluster_finder_chk #(
   parameter int ROWS     = 8,
   parameter int COLS     = 16,
   parameter int ROI_HALF = 2,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          clu_valid,
   input logic [RW-1:0] clu_row_min,
   input logic [RW-1:0] clu_row_max,
   input logic [CW-1:0] clu_col_min,
   input logic [CW-1:0] clu_col_max,
   input logic [RW-1:0] clu_seed_row,
   input logic [CW-1:0] clu_seed_col,
   input logic          defer_valid,
   input logic [RW-1:0] defer_row,
   input logic          err_overflow
);

   p_seed_in_box_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clu_valid |-> (clu_row_min <= clu_seed_row && clu_seed_row <= clu_row_max &&
                     clu_col_min <= clu_seed_col && clu_seed_col <= clu_col_max));

   p_box_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clu_valid |-> (int'(clu_row_max) - int'(clu_row_min) <= 2 * ROI_HALF &&
                     int'(clu_col_max) - int'(clu_col_min) <= 2 * ROI_HALF));

   p_defer_low_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
      defer_valid |-> (int'(defer_row) > ROWS - 1 - ROI_HALF));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy ##1 !done);

   p_drop_no_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> !clu_valid);

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

bind sc_cluster_finder sc_cluster_finder_chk #(
   .ROWS     (ROWS),
   .COLS     (COLS),
   .ROI_HALF (ROI_HALF)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .done         (done),
   .clu_valid    (clu_valid),
   .clu_row_min  (clu_row_min),
   .clu_row_max  (clu_row_max),
   .clu_col_min  (clu_col_min),
   .clu_col_max  (clu_col_max),
   .clu_seed_row (clu_seed_row),
   .clu_seed_col (clu_seed_col),
   .defer_valid  (defer_valid),
   .defer_row    (defer_row),
   .err_overflow (err_overflow)
);

// File: tb/sc_cluster_finder_tb.sv
module sc_cluster_finder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS = 8;
   localparam int COLS = 16;
   localparam int RW = 3;
   localparam int CW = 4;
   localparam int PW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic thr_we = 1'b0, thr_sel = 1'b0;
   logic [PW-1:0] thr_wdata = '0;
   logic pix_we = 1'b0;
   logic [RW+CW-1:0] pix_waddr = '0;
   logic [PW-1:0] pix_wdata = '0;
   logic start = 1'b0;
   logic busy, done, clu_valid, defer_valid, err_overflow;
   logic [RW-1:0] clu_row_min, clu_row_max, clu_seed_row, defer_row;
   logic [CW-1:0] clu_col_min, clu_col_max, clu_seed_col, defer_col;

   int n_checks = 0, n_fail = 0, cycles = 0;
   int n_clu = 0, n_def = 0, n_err = 0;
   int clu_box [16];
   int def_rc [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_cluster_finder #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PW), .MAIN_DEPTH(10)) u_dut (
      .clk, .rst_n, .thr_we, .thr_sel, .thr_wdata, .pix_we, .pix_waddr, .pix_wdata,
      .start, .busy, .done, .clu_valid, .clu_row_min, .clu_row_max, .clu_col_min,
      .clu_col_max, .clu_seed_row, .clu_seed_col, .defer_valid, .defer_row,
      .defer_col, .err_overflow
   );

   function automatic int box(int rmin, int rmax, int cmin, int cmax, int sr, int sc);
      return (rmin << 20) | (rmax << 16) | (cmin << 12) | (cmax << 8) | (sr << 4) | sc;
   endfunction

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (clu_valid) begin
            clu_box[n_clu % 16] = box(int'(clu_row_min), int'(clu_row_max), int'(clu_col_min),
                                      int'(clu_col_max), int'(clu_seed_row), int'(clu_seed_col));
            n_clu++;
         end
         if (defer_valid) begin
            def_rc[n_def % 16] = (int'(defer_row) << 4) | int'(defer_col);
            n_def++;
         end
         if (err_overflow) n_err++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      while (cycles < 150000) @(negedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
   end

   task automatic put(input int r, input int c, input int v);
      @(negedge clk);
      pix_we    = 1'b1;
      pix_waddr = (RW+CW)'((r << CW) | c);
      pix_wdata = PW'(v);
      @(negedge clk);
      pix_we    = 1'b0;
   endtask

   task automatic clear_img();
      for (int a = 0; a < ROWS * COLS; a++) put(a >> CW, a % COLS, 0);
   endtask

   task automatic set_thr(input bit sel, input int v);
      @(negedge clk);
      thr_we    = 1'b1;
      thr_sel   = sel;
      thr_wdata = PW'(v);
      @(negedge clk);
      thr_we    = 1'b0;
   endtask

   // runs one scan; returns counts seen during it
   task automatic run_scan(output int c0, output int d0, output int e0, output bit done_ok);
      int guard;
      c0 = n_clu;
      d0 = n_def;
      e0 = n_err;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      guard = 0;
      done_ok = 1'b0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      if (done) done_ok = !busy;
      @(negedge clk);
      if (done) done_ok = 1'b0;
   endtask

   task automatic t_reset();
      chk(!busy && !done && !clu_valid && !defer_valid && !err_overflow, "R9 reset outputs",
          {busy, done, clu_valid, defer_valid, err_overflow}, 0);
   endtask

   task automatic t_star3x3();
      int c0, d0, e0; bit ok;
      clear_img();
      for (int r = 2; r <= 4; r++)
         for (int c = 4; c <= 6; c++) put(r, c, (r == 3 && c == 5) ? 3000 : 1500);
      run_scan(c0, d0, e0, ok);
      chk(ok, "R10 done pulse with busy low", ok, 1);
      chk(n_clu - c0 == 1, "R5 one cluster for 3x3 star", n_clu - c0, 1);
      chk(clu_box[c0 % 16] == box(2, 4, 4, 6, 3, 5), "R2 R5 3x3 box",
          clu_box[c0 % 16], box(2, 4, 4, 6, 3, 5));
   endtask

   task automatic t_equal_thr();
      int c0, d0, e0; bit ok;
      clear_img();
      put(2, 2, 2000);
      put(5, 10, 2001);
      run_scan(c0, d0, e0, ok);
      chk(n_clu - c0 == 1, "R1 equal value not a seed", n_clu - c0, 1);
      chk(clu_box[c0 % 16] == box(5, 5, 10, 10, 5, 10), "R1 strict seed box",
          clu_box[c0 % 16], box(5, 5, 10, 10, 5, 10));
   endtask

   task automatic t_roi_limit();
      int c0, d0, e0; bit ok;
      clear_img();
      put(3, 5, 3000);
      for (int c = 6; c <= 9; c++) put(3, c, 1500);
      run_scan(c0, d0, e0, ok);
      chk(clu_box[c0 % 16] == box(3, 3, 5, 7, 3, 5), "R2 growth stops at window edge",
          clu_box[c0 % 16], box(3, 3, 5, 7, 3, 5));
   endtask

   task automatic t_corner();
      int c0, d0, e0; bit ok;
      clear_img();
      put(3, 5, 3000);
      put(4, 6, 1500);
      put(5, 7, 1500);
      run_scan(c0, d0, e0, ok);
      chk(clu_box[c0 % 16] == box(3, 4, 5, 6, 3, 5), "R3 window corner skipped",
          clu_box[c0 % 16], box(3, 4, 5, 6, 3, 5));
   endtask

   task automatic t_two_seeds();
      int c0, d0, e0; bit ok;
      clear_img();
      put(3, 5, 3000);
      put(3, 6, 3000);
      run_scan(c0, d0, e0, ok);
      chk(n_clu - c0 == 1, "R4 adjacent seeds give one cluster", n_clu - c0, 1);
      chk(clu_box[c0 % 16] == box(3, 3, 5, 6, 3, 5), "R4 first seed kept",
          clu_box[c0 % 16], box(3, 3, 5, 6, 3, 5));
   endtask

   task automatic t_grow_thr();
      int c0, d0, e0; bit ok;
      clear_img();
      for (int r = 2; r <= 4; r++)
         for (int c = 4; c <= 6; c++) put(r, c, (r == 3 && c == 5) ? 3000 : 1500);
      set_thr(1'b1, 1600);
      run_scan(c0, d0, e0, ok);
      chk(clu_box[c0 % 16] == box(3, 3, 5, 5, 3, 5), "R8 raised growing threshold",
          clu_box[c0 % 16], box(3, 3, 5, 5, 3, 5));
      set_thr(1'b1, 1000);
      set_thr(1'b0, 3500);
      run_scan(c0, d0, e0, ok);
      chk(n_clu - c0 == 0, "R8 raised seed threshold", n_clu - c0, 0);
      set_thr(1'b0, 2000);
   endtask

   task automatic t_defer();
      int c0, d0, e0; bit ok;
      clear_img();
      put(6, 3, 3000);
      put(6, 4, 1500);
      put(7, 10, 3000);
      run_scan(c0, d0, e0, ok);
      chk(n_clu - c0 == 0, "R6 low seeds not grown", n_clu - c0, 0);
      chk(n_def - d0 == 2, "R6 two deferred seeds", n_def - d0, 2);
      chk(def_rc[d0 % 16] == ((7 << 4) | 10) && def_rc[(d0 + 1) % 16] == ((6 << 4) | 3),
          "R6 deferred order last first", def_rc[d0 % 16], (7 << 4) | 10);
      chk(ok, "R10 done after drain", ok, 1);
   endtask

   task automatic t_edge();
      int c0, d0, e0; bit ok;
      clear_img();
      put(0, 0, 3000);
      put(0, 1, 1500);
      put(1, 0, 1500);
      put(1, 1, 1500);
      run_scan(c0, d0, e0, ok);
      chk(clu_box[c0 % 16] == box(0, 1, 0, 1, 0, 0), "R11 clipped corner box",
          clu_box[c0 % 16], box(0, 1, 0, 1, 0, 0));
   endtask

   task automatic t_overflow();
      int c0, d0, e0; bit ok;
      clear_img();
      for (int r = 1; r <= 5; r++)
         for (int c = 4; c <= 8; c++) put(r, c, (r == 3 && c == 6) ? 3000 : 1500);
      run_scan(c0, d0, e0, ok);
      chk(n_err - e0 >= 1, "R7 overflow flagged", n_err - e0, 1);
      chk(n_clu - c0 == 0, "R7 dropped cluster not reported", n_clu - c0, 0);
      chk(ok, "R7 scan completes after drop", ok, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_star3x3();
      t_equal_thr();
      t_roi_limit();
      t_corner();
      t_two_seeds();
      t_grow_thr();
      t_defer();
      t_edge();
      t_overflow();
      finish_run();
   end

endmodule